// File: doc/BRIEF.md
# Two-Wavefront Clause Issue Sequencer

This block feeds one vector ALU from two wavefronts. Each wavefront has a 64-element logical width, and the ALU is 16 lanes wide, so every instruction occupies the ALU for four consecutive cycles, one lane group per cycle. The block repeats an eight-cycle frame. Wavefront 0 owns the first four cycles of each frame and wavefront 1 owns the last four. A wavefront can therefore issue at most one instruction per frame, and the next instruction of the same wavefront starts eight cycles after the previous one. That spacing equals the pipeline depth, so operands are always ready and no per-instruction hazard logic exists.

Software supplies the work as clauses. A clause is a run of mutually independent instructions, described by a kind, a start address and a length. Control-flow and memory work go in clauses of their own. Dependencies between clauses are handled only at the switch: after the last beat of a clause, the wavefront's sequencer waits a fixed penalty before it accepts the next descriptor. During that wait the other wavefront keeps issuing in its own slots. A descriptor of the end kind retires the wavefront and raises its done flag.

Each wavefront has its own descriptor input with valid/ready. A descriptor transfers on a rising edge where both valid and ready are high. While ready is low the source must hold valid and the descriptor fields steady. The issue output has no ready input, because the ALU takes one beat every cycle.

Top module: `clause_wave_sequencer`

## Requirements
- R1: After reset, and for as long as reset is held, both descriptor ready outputs are high, `iss_valid` is low and both done flags are low. The first cycle after reset is frame position 0.
- R2: Frame positions 0 to 3 belong to wavefront 0 and positions 4 to 7 belong to wavefront 1. A beat appears only in its wavefront's own positions. No beats appear beyond those of the accepted clauses.
- R3: An instruction is issued as four beats in consecutive cycles, with lane-group index 0, 1, 2, 3. `iss_grp_en` has exactly bit `iss_lgrp` set.
- R4: The instructions of a clause are issued at addresses start, start+1, and so on, one per frame, exactly eight cycles apart.
- R5: If a descriptor transfers at the end of cycle a, the first beat of its clause falls on the first start of the wavefront's own slot at cycle a+2 or later.
- R6: If the last beat of a clause falls in cycle c, ready for that wavefront is low from cycle c+1 through c+SWITCH_PENALTY and is high again in cycle c+SWITCH_PENALTY+1.
- R7: A clause of length 0 issues no beats. It still costs the penalty, and ready returns SWITCH_PENALTY+1 cycles after the transfer.
- R8: The penalty of one wavefront does not delay or suppress the beats of the other wavefront.
- R9: A descriptor of kind 3 (end) issues no beats. From the next cycle onward the wavefront's done flag is high and its ready is low, and both stay that way until reset.
- R10: Every beat carries the wavefront id on `iss_wave` and the clause kind on `iss_kind`: 0 for ALU, 1 for control flow, 2 for memory.
- R11: A descriptor transfers only on an edge where both valid and ready are high. A descriptor held while ready is low transfers in the first cycle that ready is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cl_valid | input | 2 | Descriptor valid, one bit per wavefront |
| cl_ready | output | 2 | Descriptor ready, one bit per wavefront |
| cl_kind | input | 2x2 | Clause kind per wavefront (0 ALU, 1 control, 2 memory, 3 end) |
| cl_addr | input | 2xADDR_W | Clause start address per wavefront |
| cl_len | input | 2xLEN_W | Clause length in instructions per wavefront |
| iss_valid | output | 1 | Beat valid |
| iss_wave | output | 1 | Wavefront of the beat |
| iss_addr | output | ADDR_W | Instruction address of the beat |
| iss_kind | output | 2 | Clause kind of the beat |
| iss_lgrp | output | log2(VEC_LEN/ALU_LANES) | Lane-group index |
| iss_grp_en | output | VEC_LEN/ALU_LANES | One-hot lane-group enable |
| wave_done | output | 2 | Wavefront retired |

## Verification
The hardest case to reach is one wavefront sitting in its clause-switch penalty while the other is in the middle of a long clause, with both penalty windows and the slot boundaries lining up at different frame phases. The stimulus table mixes short clauses, a zero-length clause and a 15-instruction clause on the other wavefront, so the penalty windows overlap active issue. Each wavefront's next descriptor is presented at once, during the penalty, so the back-pressure release cycle is measured exactly. An end-of-program reset and a reset issued in the middle of an instruction close the run.

// File: rtl/cws_pkg.sv
package cws_pkg;
  typedef enum logic [1:0] {
    K_ALU  = 2'd0,
    K_CTRL = 2'd1,
    K_MEM  = 2'd2,
    K_END  = 2'd3
  } clause_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_RUN,
    ST_PEN,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/wf_slot_timer.sv
module wf_slot_timer #(
  parameter int PH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + 1'b1;
  end
endmodule

// File: rtl/wf_thread_seq.sv
module wf_thread_seq
  import cws_pkg::*;
#(
  parameter int ID      = 0,
  parameter int ADDR_W  = 8,
  parameter int LEN_W   = 4,
  parameter int LG      = 2,
  parameter int PENALTY = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LG:0]       phase,
  input  logic              d_valid,
  output logic              d_ready,
  input  clause_kind_e      d_kind,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [LEN_W-1:0]  d_len,
  output logic              beat_v,
  output logic [ADDR_W-1:0] beat_addr,
  output clause_kind_e      beat_kind,
  output logic [LG-1:0]     beat_lane,
  output logic              done
);
  localparam int   PC_W     = $clog2(PENALTY + 1);
  localparam logic SLOT_BIT = (ID != 0);

  seq_state_e        state;
  logic [ADDR_W-1:0] pc;
  logic [LEN_W-1:0]  rem;
  logic [PC_W-1:0]   pcnt;
  clause_kind_e      kind;

  logic          own_slot, pre_slot, slot_last;
  logic [LG-1:0] lane;

  assign lane      = phase[LG-1:0];
  assign own_slot  = (phase[LG] == SLOT_BIT);
  assign pre_slot  = !own_slot && (&lane);
  assign slot_last = own_slot && (&lane);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pc    <= '0;
      rem   <= '0;
      pcnt  <= '0;
      kind  <= K_ALU;
    end else begin
      case (state)
        ST_IDLE: if (d_valid) begin
          if (d_kind == K_END) begin
            state <= ST_DONE;
          end else begin
            kind <= d_kind;
            pc   <= d_addr;
            rem  <= d_len;
            if (d_len == '0) begin
              state <= ST_PEN;
              pcnt  <= PC_W'(PENALTY - 1);
            end else begin
              state <= ST_ARM;
            end
          end
        end
        ST_ARM: if (pre_slot) state <= ST_RUN;
        ST_RUN: if (slot_last) begin
          pc  <= pc + 1'b1;
          rem <= rem - 1'b1;
          if (rem == LEN_W'(1)) begin
            state <= ST_PEN;
            pcnt  <= PC_W'(PENALTY - 1);
          end
        end
        ST_PEN: begin
          if (pcnt == '0) state <= ST_IDLE;
          else            pcnt  <= pcnt - 1'b1;
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  assign d_ready   = (state == ST_IDLE);
  assign done      = (state == ST_DONE);
  assign beat_v    = (state == ST_RUN) && own_slot;
  assign beat_addr = pc;
  assign beat_kind = kind;
  assign beat_lane = lane;

  // R2: beats stay inside this wavefront's half of the frame
  p_beat_in_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_v |-> (phase[LG] == SLOT_BIT));

  // R3: an instruction always starts on lane group 0
  p_start_lane0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beat_v) |-> (beat_lane == '0));

  // R4: the address is steady across the beats of one instruction
  p_addr_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_v && $past(beat_v)) |-> $stable(beat_addr));

  // R4: after the last lane group the slot passes to the other wavefront
  p_slot_handoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_v && (&beat_lane)) |=> !beat_v);

  // R9: a retired wavefront stays retired and silent
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !beat_v && !d_ready));
endmodule

// File: rtl/wf_issue_mux.sv
module wf_issue_mux #(
  parameter int NW     = 2,
  parameter int ADDR_W = 8,
  parameter int LG     = 2
) (
  input  logic [NW-1:0]             src_v,
  input  logic [NW-1:0][ADDR_W-1:0] src_addr,
  input  logic [NW-1:0][1:0]        src_kind,
  input  logic [NW-1:0][LG-1:0]     src_lane,
  output logic                      iss_valid,
  output logic [$clog2(NW)-1:0]     iss_wave,
  output logic [ADDR_W-1:0]         iss_addr,
  output logic [1:0]                iss_kind,
  output logic [LG-1:0]             iss_lgrp,
  output logic [(1<<LG)-1:0]        iss_grp_en
);
  always_comb begin
    iss_valid = |src_v;
    iss_wave  = '0;
    iss_addr  = '0;
    iss_kind  = '0;
    iss_lgrp  = '0;
    for (int i = 0; i < NW; i++) begin
      if (src_v[i]) begin
        iss_wave = iss_wave | $clog2(NW)'(i);
        iss_addr = iss_addr | src_addr[i];
        iss_kind = iss_kind | src_kind[i];
        iss_lgrp = iss_lgrp | src_lane[i];
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < (1 << LG); g++) begin : g_en
      assign iss_grp_en[g] = iss_valid && (iss_lgrp == LG'(g));
    end
  endgenerate
endmodule

// File: rtl/clause_wave_sequencer.sv
module clause_wave_sequencer
  import cws_pkg::*;
#(
  parameter int VEC_LEN        = 64,
  parameter int ALU_LANES      = 16,
  parameter int ADDR_W         = 8,
  parameter int LEN_W          = 4,
  parameter int SWITCH_PENALTY = 40,
  localparam int BEATS         = VEC_LEN / ALU_LANES,
  localparam int LG            = $clog2(BEATS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cl_valid,
  output logic [1:0]            cl_ready,
  input  logic [1:0][1:0]       cl_kind,
  input  logic [1:0][ADDR_W-1:0] cl_addr,
  input  logic [1:0][LEN_W-1:0] cl_len,
  output logic                  iss_valid,
  output logic                  iss_wave,
  output logic [ADDR_W-1:0]     iss_addr,
  output logic [1:0]            iss_kind,
  output logic [LG-1:0]         iss_lgrp,
  output logic [BEATS-1:0]      iss_grp_en,
  output logic [1:0]            wave_done
);
  localparam int NW = 2;

  logic [LG:0]                 phase;
  logic [NW-1:0]               sv;
  logic [NW-1:0][ADDR_W-1:0]   sa;
  logic [NW-1:0][1:0]          sk;
  logic [NW-1:0][LG-1:0]       sl;

  wf_slot_timer #(.PH_W(LG + 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .phase(phase)
  );

  genvar w;
  generate
    for (w = 0; w < NW; w++) begin : g_seq
      clause_kind_e bk;
      wf_thread_seq #(
        .ID(w), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LG(LG), .PENALTY(SWITCH_PENALTY)
      ) u_seq (
        .clk(clk), .rst_n(rst_n), .phase(phase),
        .d_valid(cl_valid[w]), .d_ready(cl_ready[w]),
        .d_kind(clause_kind_e'(cl_kind[w])), .d_addr(cl_addr[w]), .d_len(cl_len[w]),
        .beat_v(sv[w]), .beat_addr(sa[w]), .beat_kind(bk), .beat_lane(sl[w]),
        .done(wave_done[w])
      );
      assign sk[w] = bk;
    end
  endgenerate

  wf_issue_mux #(.NW(NW), .ADDR_W(ADDR_W), .LG(LG)) u_mux (
    .src_v(sv), .src_addr(sa), .src_kind(sk), .src_lane(sl),
    .iss_valid(iss_valid), .iss_wave(iss_wave), .iss_addr(iss_addr),
    .iss_kind(iss_kind), .iss_lgrp(iss_lgrp), .iss_grp_en(iss_grp_en)
  );

  // R2: the two sequencers never drive a beat in the same cycle
  p_one_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sv));

  // R3: lane groups advance by one on consecutive beats of an instruction
  p_lane_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && (iss_lgrp != LG'(BEATS - 1))) |=>
      (iss_valid && (iss_lgrp == LG'($past(iss_lgrp) + 1'b1))));

  // R3: the enable vector is one-hot on every beat
  p_grp_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> ($countones(iss_grp_en) == 1));
endmodule

// File: tb/tb_clause_wave_sequencer.sv
module tb_clause_wave_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int P      = 40;
  localparam int ADDR_W = 8;
  localparam int LEN_W  = 4;
  localparam int NE     = 8;
  // stimulus table: wave, kind, start address, length
  localparam int PROG [NE][4] = '{
    '{0, 0, 'h10, 3}, '{1, 1, 'h80, 2}, '{0, 2, 'h40, 1}, '{1, 0, 'h90, 15},
    '{0, 0, 'h00, 0}, '{1, 0, 'hA0, 1}, '{0, 3, 0, 0},    '{1, 3, 0, 0}
  };

  logic clk = 0, rst_n = 0;
  logic dv [2];
  logic [1:0] dk [2];
  logic [ADDR_W-1:0] da [2];
  logic [LEN_W-1:0] dl [2];
  logic [1:0] cl_ready, wave_done;
  logic iss_valid, iss_wave;
  logic [ADDR_W-1:0] iss_addr;
  logic [1:0] iss_kind, iss_lgrp;
  logic [3:0] iss_grp_en;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int beats [2];
  int overlap = 0;
  bit pen0 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk or negedge rst_n) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  clause_wave_sequencer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SWITCH_PENALTY(P)) dut (
    .clk(clk), .rst_n(rst_n),
    .cl_valid({dv[1], dv[0]}), .cl_ready(cl_ready),
    .cl_kind({dk[1], dk[0]}), .cl_addr({da[1], da[0]}), .cl_len({dl[1], dl[0]}),
    .iss_valid(iss_valid), .iss_wave(iss_wave), .iss_addr(iss_addr),
    .iss_kind(iss_kind), .iss_lgrp(iss_lgrp), .iss_grp_en(iss_grp_en),
    .wave_done(wave_done)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // beat monitor: slot ownership and enable encoding
  always @(negedge clk) if (rst_n && iss_valid) begin
    beats[iss_wave]++;
    chk(((cyc % 8) / 4) == int'(iss_wave), "R2", "beat in foreign slot", cyc % 8, iss_wave * 4);
    chk(iss_grp_en == (4'b1 << iss_lgrp), "R3", "group enable", iss_grp_en, 1 << iss_lgrp);
    if (iss_wave && pen0) overlap++;
  end

  task automatic run_wave(input int w);
    int exp_acc = -1;
    for (int e = 0; e < NE; e++) begin
      if (PROG[e][0] == w) begin
        int a, s, c;
        @(negedge clk);
        dv[w] = 1; dk[w] = 2'(PROG[e][1]); da[w] = ADDR_W'(PROG[e][2]); dl[w] = LEN_W'(PROG[e][3]);
        while (!cl_ready[w]) @(negedge clk);
        a = cyc;
        if (w == 0) pen0 = 0;
        if (exp_acc >= 0) chk(a == exp_acc, "R6 R11", "accept cycle after penalty", a, exp_acc);
        @(negedge clk);
        dv[w] = 0;
        if (PROG[e][1] == 3) begin
          chk(wave_done[w] == 1'b1, "R9", "done after end clause", wave_done[w], 1);
          chk(cl_ready[w] == 1'b0, "R9", "ready after end clause", cl_ready[w], 0);
          break;
        end else if (PROG[e][3] == 0) begin
          exp_acc = a + P + 1; // R7
          if (w == 0) pen0 = 1;
        end else begin
          s = a + 2;
          while ((s % 8) != 4 * w) s++;
          for (int i = 0; i < PROG[e][3]; i++) begin
            for (int b = 0; b < 4; b++) begin
              while (cyc < s + 8 * i + b) @(negedge clk);
              chk(iss_valid === 1'b1, "R4 R5", "beat valid", iss_valid, 1);
              chk(int'(iss_wave) == w, "R10", "wave id", iss_wave, w);
              chk(int'(iss_kind) == PROG[e][1], "R10", "clause kind", iss_kind, PROG[e][1]);
              chk(int'(iss_addr) == PROG[e][2] + i, "R4", "address", iss_addr, PROG[e][2] + i);
              chk(int'(iss_lgrp) == b, "R3", "lane group", iss_lgrp, b);
            end
          end
          c = s + 8 * (PROG[e][3] - 1) + 3;
          exp_acc = c + P + 1;
          if (w == 0) pen0 = 1;
          @(negedge clk);
          chk(cl_ready[w] == 1'b0, "R6", "ready low after last beat", cl_ready[w], 0);
        end
      end
    end
  endtask

  initial begin
    bit timeout = 0;
    for (int w = 0; w < 2; w++) begin dv[w] = 0; dk[w] = 0; da[w] = 0; dl[w] = 0; beats[w] = 0; end
    repeat (3) @(negedge clk);
    chk(cl_ready == 2'b11, "R1", "ready in reset", cl_ready, 3);
    chk(iss_valid == 1'b0, "R1", "valid in reset", iss_valid, 0);
    chk(wave_done == 2'b00, "R1", "done in reset", wave_done, 0);
    rst_n = 1;
    fork
      begin
        fork
          run_wave(0);
          run_wave(1);
        join
      end
      begin
        repeat (5000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) chk(0, "ALL", "watchdog expired", 0, 1);
    repeat (10) @(negedge clk);
    chk(beats[0] == 16, "R2", "wave 0 beat total", beats[0], 16);
    chk(beats[1] == 72, "R2", "wave 1 beat total", beats[1], 72);
    chk(overlap > 0, "R8", "wave 1 beats during wave 0 penalty", overlap, 1);
    chk(wave_done == 2'b11, "R9", "done sticky", wave_done, 3);
    chk(cl_ready == 2'b00, "R9", "ready stays low when retired", cl_ready, 0);
    rst_n = 0;
    #1;
    chk(wave_done == 2'b00, "R1", "done cleared by reset", wave_done, 0);
    chk(cl_ready == 2'b11, "R1", "ready after reset", cl_ready, 3);
    @(negedge clk);
    rst_n = 1;
    dv[1] = 1; dk[1] = 0; da[1] = 8'h33; dl[1] = 4;
    @(negedge clk);
    dv[1] = 0;
    while (!iss_valid && cyc < 40) @(negedge clk);
    chk(iss_addr == 8'h33, "R4", "first address after restart", iss_addr, 'h33);
    @(negedge clk);
    rst_n = 0;
    #1;
    chk(iss_valid == 1'b0, "R1", "reset mid-instruction", iss_valid, 0);
    chk(cl_ready == 2'b11, "R1", "ready after mid-run reset", cl_ready, 3);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule